// File: doc/BRIEF.md
# Parallel SDI Scrambler and NRZI Encoder

This block takes one 10-bit video character per clock and prepares it for an external 10:1 serializer. The clock runs at one tenth of the serial bit rate. Each encoded character first goes through a self-synchronizing scrambler with the generator polynomial x^9 + x^4 + 1. The scrambler is unrolled so that all ten bits are handled in one cycle. The scrambled word then goes through an NRZ-to-NRZI converter, so a receiver does not need to know the line polarity. The scrambler history and the NRZI level carry over from one character to the next. Bit 0 of every word is the first bit on the serial line.

Two controls route a character around both stages: a bypass control, and a mode select for an alternate transport stream. A routed-around character goes to the output exactly as it came in. It leaves the scrambler and NRZI state untouched, so encoding picks up afterwards as if that character had never been sent. Both controls are sampled on the same edge as the character they travel with.

Data enters through a valid/ready port and leaves through a registered valid/ready port. Back-pressure rule: the input is ready whenever the output register is empty or is being drained in the same cycle. While the output is stalled, the output word stays fixed and no new character is taken.

Top module: `sdi_scram_nrzi_tx`

## Requirements
- R1: A synchronous active-high reset clears out_valid, out_data, the 9-bit scrambler history and the NRZI level to zero.
- R2: For an encoded character, scrambled bit n = in_data[n] XOR scrambled bit n-4 XOR scrambled bit n-9. Bit 0 is the earliest serial bit. Negative indices refer to the earlier encoded characters through the 9-bit history. From reset, in_data 0x001 scrambles to 0x311.
- R3: NRZI bit n = scrambled bit n XOR NRZI bit n-1. Bit -1 is bit 9 of the previous encoded output, or 0 after reset. From reset, in_data 0x001 yields out_data 0x10F.
- R4: A character is accepted on a rising edge where in_valid and in_ready are both 1. Its result appears on out_data, with out_valid = 1, right after that edge.
- R5: With asi_mode = 0 and bypass = 1, the accepted character appears on out_data unchanged.
- R6: With asi_mode = 1, the accepted character appears unchanged whatever the value of bypass.
- R7: A character that is bypassed or sent in the alternate mode leaves the scrambler history and NRZI level unchanged. The next encoded character is therefore encoded as if the pass-through character had never been sent.
- R8: The encoder state changes only on an accepted character. Cycles with in_valid = 0, or with a character that is not accepted, have no effect on later outputs. out_valid falls after an accepted word is drained with no new input.
- R9: While out_valid = 1 and out_ready = 0, out_data and out_valid hold and in_ready is 0.
- R10: in_ready equals (NOT out_valid) OR out_ready in the same cycle.
- R11: bypass and asi_mode take effect on the very character accepted on the same edge. Changing them between back-to-back characters changes the treatment of exactly that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A character is offered on in_data |
| in_ready | output | 1 | The block can take a character this cycle |
| in_data | input | 10 | Input character, bit 0 sent first |
| bypass | input | 1 | Pass the character through unencoded |
| asi_mode | input | 1 | Alternate-stream mode: pass through, bypass ignored |
| out_valid | output | 1 | out_data holds a result |
| out_ready | input | 1 | Downstream takes out_data this cycle |
| out_data | output | 10 | Encoded or passed-through character |

## Verification
Every accepted character reaches out_data one edge after it is accepted, so the bench drives on the falling edge and compares on the next falling edge. That is half a cycle after the capturing edge. in_ready is combinational from out_valid and out_ready, so it is sampled in the same half-cycle in which out_ready changes. Encoder state cannot be seen directly. Effects on it are judged from the next encoded character, which is compared against a bench model that advances only on characters the bench knows were accepted. In stall cases the bench holds the output for several cycles and checks on each of them that out_data is unchanged and in_ready is low.

// File: rtl/sdi_tx_pkg.sv
package sdi_tx_pkg;
  parameter int CHAR_W       = 10;
  parameter int SCR_TAP_NEAR = 4;
  parameter int SCR_TAP_FAR  = 9;
endpackage

// File: rtl/sdi_scrambler.sv
module sdi_scrambler #(
  parameter int W    = 10,
  parameter int NEAR = 4,
  parameter int FAR  = 9
) (
  input  logic [W-1:0]   din,
  input  logic [FAR-1:0] hist_in,
  output logic [W-1:0]   dout,
  output logic [FAR-1:0] hist_out
);
  localparam int XW = FAR + W;

  // x[FAR-1:0] holds prior scrambled bits (oldest at 0); x[FAR+n] is new bit n
  logic [XW-1:0] x;

  always_comb begin
    x = '0;
    x[FAR-1:0] = hist_in;
    for (int n = 0; n < W; n++) begin
      x[FAR+n] = din[n] ^ x[FAR+n-NEAR] ^ x[n];
    end
  end

  assign dout     = x[XW-1:FAR];
  assign hist_out = x[XW-1 -: FAR];
endmodule

// File: rtl/sdi_nrzi.sv
module sdi_nrzi #(
  parameter int W = 10
) (
  input  logic [W-1:0] din,
  input  logic         level_in,
  output logic [W-1:0] dout
);
  logic lvl;

  always_comb begin
    lvl  = level_in;
    dout = '0;
    for (int n = 0; n < W; n++) begin
      dout[n] = din[n] ^ lvl;
      lvl     = dout[n];
    end
  end
endmodule

// File: rtl/sdi_scram_nrzi_tx.sv
module sdi_scram_nrzi_tx
  import sdi_tx_pkg::*;
#(
  parameter int W        = CHAR_W,
  parameter int TAP_NEAR = SCR_TAP_NEAR,
  parameter int TAP_FAR  = SCR_TAP_FAR
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         bypass,
  input  logic         asi_mode,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic [TAP_FAR-1:0] hist_q, hist_d;
  logic               nrzi_q;
  logic [W-1:0]       scr_w, nrzi_w;
  logic               accept, encode;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign encode   = !asi_mode && !bypass;

  sdi_scrambler #(.W(W), .NEAR(TAP_NEAR), .FAR(TAP_FAR)) u_scr (
    .din(in_data), .hist_in(hist_q), .dout(scr_w), .hist_out(hist_d)
  );

  sdi_nrzi #(.W(W)) u_nrzi (
    .din(scr_w), .level_in(nrzi_q), .dout(nrzi_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      hist_q    <= '0;
      nrzi_q    <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= encode ? nrzi_w : in_data;
      if (encode) begin
        hist_q <= hist_d;
        nrzi_q <= nrzi_w[W-1];
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sdi_scram_nrzi_chk.sv
module sdi_scram_nrzi_chk #(
  parameter int W = 10,
  parameter int H = 9
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_data,
  input logic         bypass,
  input logic         asi_mode,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic [H-1:0] hist_q,
  input logic         nrzi_q
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0 && hist_q == '0 && !nrzi_q));

  a_r4_accept_gives_valid: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  a_r5_r6_passthrough: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (bypass || asi_mode)) |=> out_data == $past(in_data));

  a_r7_state_frozen: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (bypass || asi_mode)) |=> ($stable(hist_q) && $stable(nrzi_q)));

  a_r8_idle_frozen: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> ($stable(hist_q) && $stable(nrzi_q)));

  a_r3_level_tracks_output: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !bypass && !asi_mode) |=> nrzi_q == out_data[W-1]);

  a_r9_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r10_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);
endmodule

bind sdi_scram_nrzi_tx sdi_scram_nrzi_chk #(.W(W), .H(TAP_FAR)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .bypass(bypass), .asi_mode(asi_mode),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .hist_q(hist_q), .nrzi_q(nrzi_q)
);

// File: tb/tb_sdi_scram_nrzi_tx.sv
`timescale 1ns/1ps
module tb_sdi_scram_nrzi_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_data = '0;
  logic       bypass = 1'b0;
  logic       asi_mode = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [9:0] out_data;

  int n_chk = 0;
  int n_bad = 0;

  logic [8:0] m_hist = '0;
  logic       m_lvl  = 1'b0;

  always #2 clk = ~clk;

  sdi_scram_nrzi_tx dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .bypass(bypass), .asi_mode(asi_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bench model of R2/R3, advanced only on characters known to be encoded
  task automatic model_enc(input logic [9:0] d, output logic [9:0] q);
    logic [18:0] x;
    logic        p;
    x = {10'b0, m_hist};
    p = m_lvl;
    for (int n = 0; n < 10; n++) begin
      x[9+n] = d[n] ^ x[5+n] ^ x[n];
      q[n]   = x[9+n] ^ p;
      p      = q[n];
    end
    m_hist = x[18:10];
    m_lvl  = q[9];
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_hist = '0;
    m_lvl = 1'b0;
  endtask

  // offer one character at a falling edge, check its result one edge later
  task automatic send(input string req, input logic [9:0] d, input logic byp,
                      input logic asi, input logic [9:0] exp);
    in_data = d;
    bypass = byp;
    asi_mode = asi;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {9'b0, out_valid}, 10'd1);
    check(req, out_data, exp);
  endtask

  task automatic send_enc(input string req, input logic [9:0] d);
    logic [9:0] e;
    model_enc(d, e);
    send(req, d, 1'b0, 1'b0, e);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 out_valid", {9'b0, out_valid}, 10'd0);
    check("R1 out_data", out_data, 10'h000);
    check("R10 ready empty", {9'b0, in_ready}, 10'd1);
    send("R2 R3 R4 first char", 10'h001, 1'b0, 1'b0, 10'h10F);
  endtask

  task automatic t_patterns();
    logic [9:0] e;
    do_reset();
    model_enc(10'h001, e);
    send("R2 R3 hand value", 10'h001, 1'b0, 1'b0, 10'h10F);
    send_enc("R2 ones", 10'h3FF);
    send_enc("R2 zeros", 10'h000);
    send_enc("R2 alt a", 10'h155);
    send_enc("R2 alt b", 10'h2AA);
    send_enc("R3 msb", 10'h200);
    for (int i = 0; i < 6; i++) send_enc("R2 R3 run", 10'((i * 97 + 13) & 10'h3FF));
  endtask

  task automatic t_bypass();
    do_reset();
    send_enc("R2 pre", 10'h0F3);
    send("R5 bypass", 10'h123, 1'b1, 1'b0, 10'h123);
    send_enc("R7 after bypass", 10'h0F3);
    send("R6 asi", 10'h2C5, 1'b0, 1'b1, 10'h2C5);
    send("R6 asi bypass", 10'h05A, 1'b1, 1'b1, 10'h05A);
    send_enc("R7 after asi", 10'h3A1);
  endtask

  task automatic t_switch();
    logic [9:0] e;
    do_reset();
    // back-to-back characters with controls changing every character (R11)
    model_enc(10'h111, e);
    in_data = 10'h111; bypass = 1'b0; asi_mode = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R11 enc", out_data, e);
    in_data = 10'h222; bypass = 1'b1;
    @(negedge clk);
    check("R11 byp", out_data, 10'h222);
    model_enc(10'h333, e);
    in_data = 10'h333; bypass = 1'b0;
    @(negedge clk);
    check("R11 enc again", out_data, e);
    in_valid = 1'b0;
  endtask

  task automatic t_idle();
    do_reset();
    send_enc("R2 pre idle", 10'h0AB);
    @(negedge clk);
    check("R8 valid drops", {9'b0, out_valid}, 10'd0);
    in_data = 10'h3FF;
    repeat (3) @(negedge clk);
    send_enc("R8 after idle", 10'h0AB);
  endtask

  task automatic t_backpressure();
    logic [9:0] a;
    logic [9:0] b;
    do_reset();
    out_ready = 1'b0;
    model_enc(10'h0C3, a);
    send("R4 stalled accept", 10'h0C3, 1'b0, 1'b0, a);
    in_data = 10'h301;
    in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #0.5;
      check("R10 ready low", {9'b0, in_ready}, 10'd0);
      @(negedge clk);
      check("R9 hold data", out_data, a);
      check("R9 hold valid", {9'b0, out_valid}, 10'd1);
    end
    out_ready = 1'b1;
    #0.5;
    check("R10 ready follows out_ready", {9'b0, in_ready}, 10'd1);
    model_enc(10'h301, b);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 R8 stalled char encoded once", out_data, b);
  endtask

  task automatic t_reset_mid();
    send_enc("R2 pre reset", 10'h1E7);
    do_reset();
    check("R1 mid out_valid", {9'b0, out_valid}, 10'd0);
    send("R1 state cleared", 10'h001, 1'b0, 1'b0, 10'h10F);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_patterns();
    t_bypass();
    t_switch();
    t_idle();
    t_backpressure();
    t_reset_mid();
    finish_run();
  end
endmodule